// File: doc/BRIEF.md
# Clock-Ready Interrupt Flag Controller

This block keeps the sticky interrupt flags of a clock controller. Six stable-clock sources each report a ready level: two low-speed oscillators, a multi-speed oscillator, the internal and external high-speed oscillators, and a PLL. Each source also has an interrupt-enable bit. Two clock-failure detectors report failure levels. When a source's ready level rises while its enable is high, the matching flag latches. A rising failure level latches its own flag. Any pending flag drives a single registered interrupt line.

Software reads the flags from a read-only status word at offset 0x01C. It acknowledges a flag by writing a one to the same bit position in a write-only acknowledge word at offset 0x020. Writes use per-byte strobes, so byte, half-word and word stores all work with no wait states. The internal high-speed oscillator is special. Its flag latches only when software itself switched that oscillator on, and not when a peripheral's clock request started it.

Top module: `clk_rdy_irq`

## Requirements
- R1: After reset all flags read as zero and `irq_o` is low.
- R2: Bit positions are: source k of `osc_rdy_i` (k = 0 low-speed internal, 1 low-speed external, 2 multi-speed, 3 high-speed internal, 4 high-speed external, 5 PLL) uses flag bit k; the clock-failure flag is bit 8 and the low-speed-external failure flag is bit 9. A rising edge on `osc_rdy_i[k]`, sampled at a clock edge where `rdy_ie_i[k]` is 1, sets flag k at that edge. The flag is readable at address 0x1C in the following cycle.
- R3: A rising ready edge while the enable is 0 sets nothing. A ready level that stays high does not set a flag again after it has been cleared.
- R4: Flag bit 3 sets only if `hsi_swon_i` is 1 at the same edge as the rise. Otherwise it stays 0 and no interrupt follows.
- R5: A rising edge on `css_fail_i` sets bit 8, and a rising edge on `lse_css_fail_i` sets bit 9, whatever the enables are.
- R6: A write (`bus_sel_i` = 1, `bus_we_i` = 1) to address 0x20 clears, at that edge, every flag whose `bus_wdata_i` bit is 1 and whose byte lane is strobed. `bus_be_i[n]` qualifies bits 8n+7 to 8n.
- R7: The following have no effect on any flag: zero data bits, reserved bits, bits in lanes with a low strobe, writes to any other address, and reads.
- R8: If a set event and a clear hit the same flag at the same edge, the flag ends up set.
- R9: `irq_o` is the OR of all flags, registered: it follows the flags one clock edge later.
- R10: A read (`bus_sel_i` = 1, `bus_we_i` = 0) at 0x20 or at any address other than 0x1C returns zero. Reserved bits of the status word read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_rdy_i | input | 6 | Ready level per stable-clock source |
| rdy_ie_i | input | 6 | Ready-interrupt enable per source |
| hsi_swon_i | input | 1 | Internal high-speed oscillator switched on by software |
| css_fail_i | input | 1 | Clock-failure detector level |
| lse_css_fail_i | input | 1 | Low-speed external clock-failure level |
| bus_sel_i | input | 1 | Bus access select |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address offset |
| bus_be_i | input | 4 | Byte-lane strobes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
Flags change at the rising edge where a set or clear is sampled, so a read shows the result in the cycle after that edge. `irq_o` trails the flags by one further edge. The bench drives all inputs just after a falling edge and updates its reference model at each rising edge. It compares the read data and `irq_o` 1 ns after the next falling edge, so every check sits between the edge that produced a result and the edge that could change it. Directed sequences cover the priority, qualifier and byte-lane cases. A seeded random phase then mixes toggling levels with reads and writes.

// File: rtl/clk_rdy_irq_pkg.sv
package clk_rdy_irq_pkg;
  localparam int BUS_W   = 32;
  localparam int LANES   = BUS_W / 8;
  localparam int NUM_OSC = 6;
  localparam int NUM_EDG = NUM_OSC + 2;
  localparam int ADDR_W  = 8;

  localparam int B_LSI  = 0;
  localparam int B_LSE  = 1;
  localparam int B_MSI  = 2;
  localparam int B_HSI  = 3;
  localparam int B_HSE  = 4;
  localparam int B_PLL  = 5;
  localparam int B_CSS  = 8;
  localparam int B_LCSS = 9;

  localparam logic [BUS_W-1:0] FLAG_MASK = 32'h0000_033F;
  localparam logic [ADDR_W-1:0] OFFS_STAT = 8'h1C;
  localparam logic [ADDR_W-1:0] OFFS_ACK  = 8'h20;
endpackage

// File: rtl/cri_edge_det.sv
module cri_edge_det #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/cri_ack_dec.sv
module cri_ack_dec #(
  parameter int              ADDR_W = 8,
  parameter int              BUS_W  = 32,
  parameter logic [ADDR_W-1:0] OFFS = '0,
  parameter logic [BUS_W-1:0]  MASK = '0
) (
  input  logic                 sel_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BUS_W/8-1:0]   be_i,
  input  logic [BUS_W-1:0]     wdata_i,
  output logic [BUS_W-1:0]     clr_o
);
  localparam int LANES = BUS_W / 8;
  logic             hit;
  logic [BUS_W-1:0] lane_m;

  assign hit = sel_i & we_i & (addr_i == OFFS);

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    assign lane_m[8*n +: 8] = {8{be_i[n]}};
  end

  assign clr_o = hit ? (wdata_i & lane_m & MASK) : '0;
endmodule

// File: rtl/cri_flag_bank.sv
module cri_flag_bank #(
  parameter int             BUS_W = 32,
  parameter logic [BUS_W-1:0] MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] set_i,
  input  logic [BUS_W-1:0] clr_i,
  output logic [BUS_W-1:0] flags_o
);
  for (genvar i = 0; i < BUS_W; i++) begin : g_bit
    if (MASK[i]) begin : g_flop
      logic bit_q;
      // set has priority so an event coinciding with an ack survives
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       bit_q <= 1'b0;
        else if (set_i[i]) bit_q <= 1'b1;
        else if (clr_i[i]) bit_q <= 1'b0;
      end
      assign flags_o[i] = bit_q;
    end else begin : g_rsvd
      assign flags_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/clk_rdy_irq.sv
module clk_rdy_irq
  import clk_rdy_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_OSC-1:0]   osc_rdy_i,
  input  logic [NUM_OSC-1:0]   rdy_ie_i,
  input  logic                 hsi_swon_i,
  input  logic                 css_fail_i,
  input  logic                 lse_css_fail_i,
  input  logic                 bus_sel_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [LANES-1:0]     bus_be_i,
  input  logic [BUS_W-1:0]     bus_wdata_i,
  output logic [BUS_W-1:0]     bus_rdata_o,
  output logic                 irq_o
);
  logic [NUM_EDG-1:0] rise;
  logic [BUS_W-1:0]   evt;
  logic [BUS_W-1:0]   clr_mask;
  logic [BUS_W-1:0]   flags_q;
  logic               irq_q;

  cri_edge_det #(.W(NUM_EDG)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({lse_css_fail_i, css_fail_i, osc_rdy_i}),
    .rise_o (rise)
  );

  always_comb begin
    evt = '0;
    evt[NUM_OSC-1:0] = rise[NUM_OSC-1:0] & rdy_ie_i;
    // peripheral-requested wake of the internal HS oscillator must not flag
    evt[B_HSI]  = evt[B_HSI] & hsi_swon_i;
    evt[B_CSS]  = rise[NUM_OSC];
    evt[B_LCSS] = rise[NUM_OSC+1];
  end

  cri_ack_dec #(
    .ADDR_W (ADDR_W),
    .BUS_W  (BUS_W),
    .OFFS   (OFFS_ACK),
    .MASK   (FLAG_MASK)
  ) u_ack (
    .sel_i   (bus_sel_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .be_i    (bus_be_i),
    .wdata_i (bus_wdata_i),
    .clr_o   (clr_mask)
  );

  cri_flag_bank #(
    .BUS_W (BUS_W),
    .MASK  (FLAG_MASK)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (evt),
    .clr_i   (clr_mask),
    .flags_o (flags_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |flags_q;
  end

  assign irq_o       = irq_q;
  assign bus_rdata_o = (bus_sel_i && !bus_we_i && bus_addr_i == OFFS_STAT) ? flags_q : '0;
endmodule

// File: rtl/clk_rdy_irq_chk.sv
module clk_rdy_irq_chk
  import clk_rdy_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_W-1:0]  flags_i,
  input  logic [BUS_W-1:0]  evt_i,
  input  logic [BUS_W-1:0]  clr_i,
  input  logic              hsi_swon_i,
  input  logic              irq_o,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_rdata_o
);
  logic pv_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pv_q <= 1'b0;
    else         pv_q <= 1'b1;
  end

  // R2
  flag_rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i & ~FLAG_MASK) == '0);

  // R8
  set_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q |-> (($past(evt_i) & ~flags_i) == '0));

  // R6
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q |-> (($past(clr_i & ~evt_i) & flags_i) == '0));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q |-> ((flags_i & ~$past(flags_i) & ~$past(evt_i)) == '0));

  // R4
  hsi_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && $rose(flags_i[B_HSI])) |-> $past(hsi_swon_i));

  // R9
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q |-> (irq_o == (|$past(flags_i))));

  // R10
  ack_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_we_i && bus_addr_i != OFFS_STAT) |-> (bus_rdata_o == '0));
endmodule

bind clk_rdy_irq clk_rdy_irq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flags_i     (flags_q),
  .evt_i       (evt),
  .clr_i       (clr_mask),
  .hsi_swon_i  (hsi_swon_i),
  .irq_o       (irq_o),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o)
);

// File: tb/clk_rdy_irq_tb.sv
module clk_rdy_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  rdy = '0, ie = '0;
  logic        swon = 1'b0, cssf = 1'b0, lcssf = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        irq;

  int checks = 0, errors = 0;
  logic [31:0] flags_m;
  logic        irq_m;
  logic [7:0]  prev_m;

  always #10 clk = ~clk;

  clk_rdy_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_rdy_i(rdy), .rdy_ie_i(ie),
    .hsi_swon_i(swon), .css_fail_i(cssf), .lse_css_fail_i(lcssf),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_be_i(be),
    .bus_wdata_i(wd), .bus_rdata_o(rd), .irq_o(irq)
  );

  function automatic logic [31:0] ev_f(logic [7:0] cur, logic [7:0] prv,
                                       logic [5:0] en, logic sw);
    logic [7:0]  r = cur & ~prv;
    logic [31:0] e = '0;
    e[5:0] = r[5:0] & en;
    if (!sw) e[3] = 1'b0;
    e[8] = r[6];
    e[9] = r[7];
    return e;
  endfunction

  function automatic logic [31:0] clr_f(logic s, logic w, logic [7:0] a,
                                        logic [3:0] b, logic [31:0] d);
    logic [31:0] m = '0;
    if (!(s && w && a == 8'h20)) return '0;
    for (int n = 0; n < 4; n++) if (b[n]) m[8*n +: 8] = 8'hFF;
    return d & m & 32'h0000_033F;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_m = '0; irq_m = 1'b0; prev_m = '0;
    end else begin
      logic [31:0] e, c;
      e = ev_f({lcssf, cssf, rdy}, prev_m, ie, swon);
      c = clr_f(sel, we, addr, be, wd);
      irq_m   = |flags_m;
      flags_m = (flags_m & ~c) | e;
      prev_m  = {lcssf, cssf, rdy};
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_idle();
    sel = 1'b0; we = 1'b0; addr = '0; be = '0; wd = '0;
  endtask

  // called just after a falling edge: compare status and irq against model
  task automatic observe(string tag);
    sel = 1'b1; we = 1'b0; addr = 8'h1C;
    #1;
    chk({tag, " flags"}, rd, flags_m);
    chk({tag, " irq R9"}, {31'd0, irq}, {31'd0, irq_m});
    bus_idle();
  endtask

  task automatic ack(logic [7:0] a, logic [3:0] b, logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; be = b; wd = d;
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nxt();
    // R1
    observe("R1");
    chk("R1 rd flag", rd, 32'h0);
    sel = 1'b1; addr = 8'h20; #1;
    // R10
    chk("R10 ack read", rd, 32'h0);
    addr = 8'h44; #1;
    chk("R10 other read", rd, 32'h0);
    bus_idle();

    // R2: enabled rise on LSI
    ie = 6'h3F; swon = 1'b1; rdy[0] = 1'b1;
    nxt(); observe("R2");
    chk("R2 bit0", {31'd0, flags_m[0]}, 32'd1);
    nxt(); observe("R9");
    chk("R9 irq high", {31'd0, irq}, 32'd1);

    // R3: clear while ready stays high, no re-set
    ack(8'h20, 4'b0001, 32'h1);
    nxt(); observe("R3 after clear");
    nxt(); nxt(); observe("R3 level held");
    chk("R3 bit0 stays clear", {31'd0, rd[0]}, 32'd0);
    ie[1] = 1'b0; rdy[1] = 1'b1;
    nxt(); observe("R3 disabled rise");
    ie[1] = 1'b1;
    nxt(); observe("R3 enable after rise");

    // R4: HS internal qualifier
    swon = 1'b0; rdy[3] = 1'b1;
    nxt(); observe("R4 no swon");
    rdy[3] = 1'b0; nxt();
    swon = 1'b1; rdy[3] = 1'b1;
    nxt(); observe("R4 swon");

    // R5: failure flags ignore enables
    ie = '0; cssf = 1'b1; lcssf = 1'b1;
    nxt(); observe("R5");

    // R6/R7: lane strobes, reserved bits, other address
    ack(8'h20, 4'b0001, 32'h0000_0100);
    nxt(); observe("R7 lane off");
    ack(8'h1C, 4'hF, 32'hFFFF_FFFF);
    nxt(); observe("R7 other addr");
    ack(8'h20, 4'hF, 32'hFFFF_FCC0);
    nxt(); observe("R7 reserved/zero");
    ack(8'h20, 4'b0010, 32'h0000_0300);
    nxt(); observe("R6 byte lane1");
    ack(8'h20, 4'b0011, 32'h0000_0008);
    nxt(); observe("R6 halfword");

    // R8: set and clear same edge
    ie = 6'h3F; rdy[5] = 1'b1;
    ack(8'h20, 4'hF, 32'h0000_0020);
    nxt(); observe("R8");
    chk("R8 bit5 set", {31'd0, flags_m[5]}, 32'd1);
    ack(8'h20, 4'hF, 32'hFFFF_FFFF);
    nxt(); nxt(); observe("R9 all clear");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int op;
      for (int k = 0; k < 6; k++) if ($urandom_range(0, 7) == 0) rdy[k] = ~rdy[k];
      if ($urandom_range(0, 15) == 0) ie = 6'($urandom);
      if ($urandom_range(0, 15) == 0) swon = ~swon;
      if ($urandom_range(0, 31) == 0) cssf = ~cssf;
      if ($urandom_range(0, 31) == 0) lcssf = ~lcssf;
      op = $urandom_range(0, 3);
      if (op == 0)      ack(8'h20, 4'($urandom), $urandom);
      else if (op == 1) ack(($urandom_range(0, 1) == 0) ? 8'h1C : 8'h24, 4'hF, $urandom);
      nxt();
      observe("R2/R6 random");
    end
    summary();
  end
endmodule